// File: doc/BRIEF.md
# Embedded Core Test Collar

This block wraps the terminals of an embedded core so that the core and the wiring around it can be tested apart from each other. Every core input terminal and every core output terminal passes through its own boundary cell. Each cell has a serial stage and a separate hold latch. All the serial stages are linked into one chain between a scan input and a registered scan output. The input-side cells come first in the chain, then the output-side cells, so the chain can be cascaded with other collars.

A two-bit mode code and three strobes (capture, shift, update) arrive from the chip's test instruction logic. In functional mode the collar is transparent. In external test mode the output-side cells drive the host nets from their latches. In internal test mode the input-side cells drive the core from their latches. Capture always samples the value that arrives at each cell from its functional side. Shifting never disturbs a driven terminal, because the terminals follow the latches and not the serial stages.

Top module: `core_wrapper`

## Requirements
- R1: Mode code 2'b00 (functional) makes `core_in_o` equal `host_in_i` and `host_out_o` equal `core_out_i`, both combinationally.
- R2: Mode code 2'b01 (external test) makes `host_out_o` equal the output-side latches, while `core_in_o` keeps following `host_in_i`.
- R3: Mode code 2'b10 (internal test) makes `core_in_o` equal the input-side latches, while `host_out_o` keeps following `core_out_i`.
- R4: On a clock edge that samples capture, the chain loads `{core_out_i, host_in_i}`. Chain position p < NUM_IN holds `host_in_i[p]`, and the higher positions hold `core_out_i[p-NUM_IN]`.
- R5: On each clock edge that samples shift, the chain moves by one position: `scan_in_i` enters position 0 and position p takes the old position p-1.
- R6: On a clock edge that samples update, every latch takes its cell's chain bit, and the driven terminals show the new value right after that edge.
- R7: While shift or capture is active, the latches and so the driven terminals keep their values.
- R8: `scan_out_o` is a register that holds, after each edge, the last chain position (NUM_IN+NUM_OUT-1) as it stood before that edge.
- R9: The strobes have a fixed priority, highest first: shift, then capture, then update. A strobe that is outranked in the same cycle has no effect.
- R10: Reset (`rst_n` low, asynchronous) clears every chain bit, every latch and `scan_out_o`. Mode code 2'b11 behaves exactly as functional mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Mode code: 00 functional, 01 external, 10 internal, 11 functional |
| capture_i | input | 1 | Capture strobe |
| shift_i | input | 1 | Shift strobe |
| update_i | input | 1 | Update strobe |
| scan_in_i | input | 1 | Serial data into chain position 0 |
| scan_out_o | output | 1 | Registered serial data from the last chain position |
| host_in_i | input | NUM_IN | Host nets that feed the core inputs |
| core_in_o | output | NUM_IN | Core input terminals |
| core_out_i | input | NUM_OUT | Core output terminals |
| host_out_o | output | NUM_OUT | Host nets fed by the core outputs |

## Verification
The terminal paths are combinational from the mode and the latches, so they are checked in the same cycle the mode or the pins change. After an update they are checked just after the update edge. A capture fills the chain at its own edge. Because of the output register, chain position NUM_IN+NUM_OUT-k shows up on `scan_out_o` right after the k-th following shift edge. The bench samples every result at the falling edge that follows the edge where the result is due. It drives all stimulus on falling edges.

// File: rtl/wrap_pkg.sv
package wrap_pkg;

  typedef enum logic [1:0] {
    MODE_FUNC = 2'b00,
    MODE_EXT  = 2'b01,
    MODE_INT  = 2'b10,
    MODE_RSVD = 2'b11
  } wmode_e;

  // Input-side cells take over the core terminals only in internal test.
  function automatic logic core_side_driven(input wmode_e m);
    return (m == MODE_INT);
  endfunction

  // Output-side cells take over the host nets only in external test.
  function automatic logic host_side_driven(input wmode_e m);
    return (m == MODE_EXT);
  endfunction

  // Chain position of output-side cell j.
  function automatic int out_cell_pos(input int num_in, input int j);
    return num_in + j;
  endfunction

endpackage

// File: rtl/wrap_ctrl.sv
module wrap_ctrl
  import wrap_pkg::*;
(
  input  logic       capture_i,
  input  logic       shift_i,
  input  logic       update_i,
  input  logic [1:0] mode_i,
  output logic       shift_en,
  output logic       capture_en,
  output logic       update_en,
  output logic       drive_core_en,
  output logic       drive_host_en
);

  wmode_e mode;
  assign mode = wmode_e'(mode_i);

  // Strobe priority: shift, then capture, then update (R9).
  assign shift_en   = shift_i;
  assign capture_en = capture_i & ~shift_i;
  assign update_en  = update_i & ~shift_i & ~capture_i;

  assign drive_core_en = core_side_driven(mode);
  assign drive_host_en = host_side_driven(mode);

endmodule

// File: rtl/wrap_cell.sv
module wrap_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic shift_en,
  input  logic capture_en,
  input  logic update_en,
  input  logic drive_en,
  input  logic scan_i,
  input  logic func_i,
  output logic stage_o,
  output logic latch_o,
  output logic term_o
);

  logic stage_q;
  logic latch_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          stage_q <= 1'b0;
    else if (shift_en)   stage_q <= scan_i;
    else if (capture_en) stage_q <= func_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         latch_q <= 1'b0;
    else if (update_en) latch_q <= stage_q;
  end

  assign stage_o = stage_q;
  assign latch_o = latch_q;
  assign term_o  = drive_en ? latch_q : func_i;

endmodule

// File: rtl/core_wrapper.sv
module core_wrapper
  import wrap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         mode_i,
  input  logic               capture_i,
  input  logic               shift_i,
  input  logic               update_i,
  input  logic               scan_in_i,
  output logic               scan_out_o,
  input  logic [NUM_IN-1:0]  host_in_i,
  output logic [NUM_IN-1:0]  core_in_o,
  input  logic [NUM_OUT-1:0] core_out_i,
  output logic [NUM_OUT-1:0] host_out_o
);

  localparam int CHAIN_LEN = NUM_IN + NUM_OUT;
  localparam int TAIL      = CHAIN_LEN - 1;

  logic shift_en, capture_en, update_en;
  logic drive_core_en, drive_host_en;

  logic [CHAIN_LEN-1:0] stage_q;
  logic [CHAIN_LEN-1:0] upd_q;
  logic [CHAIN_LEN-1:0] term_vec;
  logic [CHAIN_LEN-1:0] func_vec;
  logic                 chain_tail;
  logic                 so_q;

  assign func_vec = {core_out_i, host_in_i};

  wrap_ctrl u_ctrl (
    .capture_i     (capture_i),
    .shift_i       (shift_i),
    .update_i      (update_i),
    .mode_i        (mode_i),
    .shift_en      (shift_en),
    .capture_en    (capture_en),
    .update_en     (update_en),
    .drive_core_en (drive_core_en),
    .drive_host_en (drive_host_en)
  );

  for (genvar p = 0; p < CHAIN_LEN; p++) begin : g_cell
    logic scan_feed;
    logic drv;
    if (p == 0) begin : g_head
      assign scan_feed = scan_in_i;
    end else begin : g_link
      assign scan_feed = stage_q[p-1];
    end
    if (p < NUM_IN) begin : g_core_side
      assign drv = drive_core_en;
    end else begin : g_host_side
      assign drv = drive_host_en;
    end
    wrap_cell u_cell (
      .clk        (clk),
      .rst_n      (rst_n),
      .shift_en   (shift_en),
      .capture_en (capture_en),
      .update_en  (update_en),
      .drive_en   (drv),
      .scan_i     (scan_feed),
      .func_i     (func_vec[p]),
      .stage_o    (stage_q[p]),
      .latch_o    (upd_q[p]),
      .term_o     (term_vec[p])
    );
  end

  assign core_in_o  = term_vec[NUM_IN-1:0];
  assign host_out_o = term_vec[out_cell_pos(NUM_IN, NUM_OUT-1):out_cell_pos(NUM_IN, 0)];

  assign chain_tail = stage_q[TAIL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) so_q <= 1'b0;
    else        so_q <= chain_tail;
  end

  assign scan_out_o = so_q;

endmodule

// File: rtl/wrap_checker.sv
module wrap_checker
  import wrap_pkg::*;
#(
  parameter int NUM_IN  = 4,
  parameter int NUM_OUT = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [1:0]                 mode_i,
  input logic                       scan_in_i,
  input logic                       scan_out_o,
  input logic [NUM_IN-1:0]          host_in_i,
  input logic [NUM_IN-1:0]          core_in_o,
  input logic [NUM_OUT-1:0]         core_out_i,
  input logic [NUM_OUT-1:0]         host_out_o,
  input logic [NUM_IN+NUM_OUT-1:0]  stage_q,
  input logic [NUM_IN+NUM_OUT-1:0]  upd_q,
  input logic                       shift_en,
  input logic                       capture_en,
  input logic                       update_en
);

  localparam int N = NUM_IN + NUM_OUT;

  AST_CORE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_INT) |-> (core_in_o == host_in_i)); // R1
  AST_HOST_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i != MODE_EXT) |-> (host_out_o == core_out_i)); // R1
  AST_EXT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_EXT) |-> (host_out_o == upd_q[N-1:NUM_IN])); // R2
  AST_INT_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == MODE_INT) |-> (core_in_o == upd_q[NUM_IN-1:0])); // R3
  AST_CAPTURE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    capture_en |=> (stage_q == $past({core_out_i, host_in_i}))); // R4
  AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (stage_q == $past({stage_q[N-2:0], scan_in_i}))); // R5
  AST_UPDATE_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    update_en |=> (upd_q == $past(stage_q))); // R6
  AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en || capture_en) |=> $stable(upd_q)); // R7
  AST_SO_REGISTERED: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (scan_out_o == $past(stage_q[N-1]))); // R8
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({shift_en, capture_en, update_en})); // R9

endmodule

bind core_wrapper wrap_checker #(.NUM_IN(NUM_IN), .NUM_OUT(NUM_OUT)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_i     (mode_i),
  .scan_in_i  (scan_in_i),
  .scan_out_o (scan_out_o),
  .host_in_i  (host_in_i),
  .core_in_o  (core_in_o),
  .core_out_i (core_out_i),
  .host_out_o (host_out_o),
  .stage_q    (stage_q),
  .upd_q      (upd_q),
  .shift_en   (shift_en),
  .capture_en (capture_en),
  .update_en  (update_en)
);

// File: tb/tb_core_wrapper.sv
module tb_core_wrapper;

  localparam int CLK_PERIOD = 10;
  localparam int NI = 4;
  localparam int NO = 4;
  localparam int N  = NI + NO;
  localparam int NVEC = 8;

  // {mode(4), chain pattern(8), host_in(4), core_out(4)}
  localparam logic [19:0] VEC [NVEC] = '{
    {4'h0, 8'hA5, 4'h3, 4'hC},
    {4'h1, 8'h5A, 4'h9, 4'h6},
    {4'h2, 8'h3C, 4'hF, 4'h0},
    {4'h1, 8'hF0, 4'h0, 4'hF},
    {4'h2, 8'h0F, 4'hA, 4'h5},
    {4'h3, 8'hFF, 4'h6, 4'h9},
    {4'h2, 8'h81, 4'h5, 4'hA},
    {4'h1, 8'h7E, 4'hC, 4'h3}
  };

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0] mode;
  logic capture, shift, update, si, so;
  logic [NI-1:0] host_in, core_in;
  logic [NO-1:0] core_out, host_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  core_wrapper #(.NUM_IN(NI), .NUM_OUT(NO)) dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .capture_i(capture),
    .shift_i(shift), .update_i(update), .scan_in_i(si), .scan_out_o(so),
    .host_in_i(host_in), .core_in_o(core_in), .core_out_i(core_out),
    .host_out_o(host_out)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic shift_pattern(input logic [7:0] pat, input logic with_update);
    for (int k = 1; k <= N; k++) begin
      si = pat[N-k];
      shift = 1'b1;
      update = with_update;
      tick();
    end
    shift = 1'b0;
    update = 1'b0;
    si = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [1:0] m;
    logic [7:0] pat, cap;
    logic [3:0] hi, co, exp_ci, exp_ho;
    rst_n = 1'b0; mode = 2'b00; capture = 0; shift = 0; update = 0; si = 0;
    host_in = 4'h5; core_out = 4'hA;
    repeat (3) @(negedge clk);
    // R10 reset state, R1 functional pass-through
    check("R10 scan_out after reset", {7'b0, so}, 8'h00);
    check("R1 core_in functional", {4'b0, core_in}, 8'h05);
    check("R1 host_out functional", {4'b0, host_out}, 8'h0A);
    rst_n = 1'b1;
    tick();
    mode = 2'b10;
    #1;
    check("R10 latches cleared (internal mode)", {4'b0, core_in}, 8'h00);
    mode = 2'b01;
    #1;
    check("R10 latches cleared (external mode)", {4'b0, host_out}, 8'h00);

    // Table-driven walk: load, update, check drive, capture, unload.
    for (int v = 0; v < NVEC; v++) begin
      m = VEC[v][17:16]; pat = VEC[v][15:8]; hi = VEC[v][7:4]; co = VEC[v][3:0];
      mode = m; host_in = hi; core_out = co;
      shift_pattern(pat, 1'b0);
      update = 1'b1;
      tick();
      update = 1'b0;
      exp_ci = (m == 2'b10) ? pat[3:0] : hi;
      exp_ho = (m == 2'b01) ? pat[7:4] : co;
      check("R1/R2/R3/R6/R10 core_in after update", {4'b0, core_in}, {4'b0, exp_ci});
      check("R1/R2/R3/R6/R10 host_out after update", {4'b0, host_out}, {4'b0, exp_ho});
      capture = 1'b1;
      tick();
      capture = 1'b0;
      cap = {co, hi};
      for (int k = 1; k <= N; k++) begin
        shift = 1'b1;
        si = 1'b0;
        tick();
        check("R4/R5/R8 scan_out bit", {7'b0, so}, {7'b0, cap[N-k]});
      end
      shift = 1'b0;
      // R7: shifting and capture left the driven terminals as updated
      check("R7 core_in held through shift", {4'b0, core_in}, {4'b0, exp_ci});
      check("R7 host_out held through shift", {4'b0, host_out}, {4'b0, exp_ho});
    end

    // R9: update held together with shift has no effect on the latches.
    mode = 2'b10; host_in = 4'h6;
    shift_pattern(8'h00, 1'b0);
    update = 1'b1; tick(); update = 1'b0;
    check("R9 latches zero before priority test", {4'b0, core_in}, 8'h00);
    shift_pattern(8'hFF, 1'b1);
    check("R9 update outranked by shift", {4'b0, core_in}, 8'h00);
    // R9: capture outranks update in the same cycle.
    capture = 1'b1; update = 1'b1; tick(); capture = 1'b0; update = 1'b0;
    check("R9 update outranked by capture", {4'b0, core_in}, 8'h00);
    update = 1'b1; tick(); update = 1'b0;
    check("R4/R6 captured host value now driven", {4'b0, core_in}, 8'h06);
    // R9: shift outranks capture: chain carries shifted data, not pins.
    capture = 1'b1; shift = 1'b1; si = 1'b1; tick();
    capture = 1'b0; shift = 1'b0; si = 1'b0;
    update = 1'b1; tick(); update = 1'b0;
    check("R9 capture outranked by shift", {4'b0, core_in}, 8'h0D);
    // R10: mode 11 acts as functional
    mode = 2'b11; host_in = 4'h9; core_out = 4'h3;
    #1;
    check("R10 reserved mode core_in", {4'b0, core_in}, 8'h09);
    check("R10 reserved mode host_out", {4'b0, host_out}, 8'h03);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule